// File: doc/BRIEF.md
# Reset Pin Glitch Filter

This block sits between the asynchronous, active-low external reset pin and the chip's reset controller. It turns the raw pin into a clean, active-high reset request, `rst_req`. Short disturbances on the pin are rejected by one of two filters. The first is a bus-clock filter whose required stable length can be programmed from 1 to 32 bus clocks. The second is a fixed filter clocked by the always-running low-power clock. Before any counting, the raw pin passes through a two-flop synchroniser in each clock domain.

Which filter is active depends on the power mode. A two-bit field chooses the filter for run and wait operation. A single bit chooses it for stop operation, where the bus-clock filter cannot be used. When neither filter is selected, the synchronised pin goes straight to the output. A filter that is not selected is held in its cleared state, and so is a filter whose clock domain is stopped. When it is selected again, it therefore starts from a fresh count.

Software reaches the settings through a small byte-wide write port with a combinational read-back. The two settings registers are cleared only by power-on reset, and no other reset disturbs them.

Top module: `rstpin_glitch_filter`

## Requirements
- R1: After `por_n` is released with the pin high, `rst_req` is 0 and both settings registers read 0x00.
- R2: The register at address 4 holds the run/wait select in bits 1:0 and the stop select in bit 2. The register at address 5 holds the bus filter width in bits 4:0. Unused bits, and every other address, read as zero.
- R3: With run/wait select 00 (not in stop), the filter is bypassed: `rst_req` equals the inverted pin two bus clocks after a pin change, and even a one-clock pulse passes through.
- R4: With run/wait select 01 (not in stop), `rst_req` changes only after the synchronised pin has held a new level for width+1 consecutive bus clocks. The output edge comes 2+width+1 bus clocks after the pin edge, and any shorter pulse is rejected.
- R5: With run/wait select 10 (not in stop), or with stop select 1 while `stop_mode` is high, the low-power filter is used. It requires 3 consecutive low-power clocks after its own two-flop synchroniser.
- R6: Run/wait select 11 enables neither filter, and the pin is passed through as in bypass.
- R7: While `stop_mode` is high, the run/wait select is ignored. Stop select 0 bypasses filtering and stop select 1 selects the low-power filter.
- R8: The bus filter is cleared while it is deselected or while `stop_mode` is high. After either condition ends, its count restarts from zero.
- R9: The low-power filter is cleared while it is deselected or while `lls_mode` is high. While it is selected and held clear, `rst_req` stays 0.
- R10: The settings registers keep their contents through mode changes and filter activity, and return to zero only on `por_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock; register port and bus filter |
| clk_lp | input | 1 | Low-power clock for the fixed filter |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pin_n | input | 1 | Raw external reset pin, active low, asynchronous |
| stop_mode | input | 1 | Device is in a stop mode |
| lls_mode | input | 1 | Device is in a low-leakage stop mode |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| rst_req | output | 1 | Filtered reset request, active high |

## Verification
The hardest case to reach is a filter clear that lands in the middle of a count. If the clear were missing, the output would only assert a few cycles early, and a simple pulse test would not notice. To reach it, the stimulus holds the pin low partway through a 32-clock window. It then briefly deselects the bus filter, or briefly raises `stop_mode`, and samples the output at a point where an uncleared count would already have fired but a restarted one cannot have. The low-power filter is treated the same way by holding `lls_mode` high across a long pin assertion and then releasing it.

// File: rtl/rpf_pkg.sv
package rpf_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_BUS  = 2'd1,
    SEL_LP   = 2'd2
  } flt_sel_e;

  // Mode-dependent choice of the active filter.
  function automatic flt_sel_e pick_filter(input logic [1:0] run_sel,
                                           input logic stop_sel,
                                           input logic in_stop);
    flt_sel_e s;
    if (in_stop)              s = stop_sel ? SEL_LP : SEL_NONE;
    else if (run_sel == 2'b01) s = SEL_BUS;
    else if (run_sel == 2'b10) s = SEL_LP;
    else                      s = SEL_NONE;
    return s;
  endfunction

endpackage

// File: rtl/rpf_sync.sv
module rpf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rpf_stable_filter.sv
module rpf_stable_filter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             din,
  input  logic [CNT_W-1:0] need_m1,
  output logic             lvl
);
  logic [CNT_W-1:0] run_q;
  logic             lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
      run_q <= '0;
    end else if (clr) begin
      lvl_q <= 1'b1;
      run_q <= '0;
    end else if (din == lvl_q) begin
      run_q <= '0;
    end else if (run_q == need_m1) begin
      lvl_q <= din;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign lvl = lvl_q;
endmodule

// File: rtl/rpf_regs.sv
module rpf_regs #(
  parameter int ADDR_W     = 3,
  parameter int WB         = 5,
  parameter int CTRL_ADDR  = 4,
  parameter int WIDTH_ADDR = 5
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [1:0]        run_sel,
  output logic              stop_sel,
  output logic [WB-1:0]     width
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      run_sel  <= '0;
      stop_sel <= 1'b0;
      width    <= '0;
    end else if (we) begin
      if (addr == ADDR_W'(CTRL_ADDR)) begin
        run_sel  <= wdata[1:0];
        stop_sel <= wdata[2];
      end
      if (addr == ADDR_W'(WIDTH_ADDR)) width <= wdata[WB-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(CTRL_ADDR))  rdata[2:0]    = {stop_sel, run_sel};
    if (addr == ADDR_W'(WIDTH_ADDR)) rdata[WB-1:0] = width;
  end
endmodule

// File: rtl/rstpin_glitch_filter.sv
module rstpin_glitch_filter
  import rpf_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int WIDTH_BITS  = 5,
  parameter int LP_COUNT    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_bus,
  input  logic              clk_lp,
  input  logic              por_n,
  input  logic              pin_n,
  input  logic              stop_mode,
  input  logic              lls_mode,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              rst_req
);
  localparam int LP_CW   = (LP_COUNT > 2) ? $clog2(LP_COUNT) : 1;
  localparam int N_DOM   = 2;
  localparam int DOM_BUS = 0;
  localparam int DOM_LP  = 1;

  logic [1:0]            run_sel;
  logic                  stop_sel;
  logic [WIDTH_BITS-1:0] width;
  flt_sel_e              sel;

  logic [N_DOM-1:0] dom_clk;
  logic [N_DOM-1:0] dom_sync;
  logic             bus_sync, lp_sync;
  logic             bus_clr, lp_clr;
  logic             bus_lvl, lp_lvl;

  rpf_regs #(
    .ADDR_W(ADDR_W), .WB(WIDTH_BITS), .CTRL_ADDR(4), .WIDTH_ADDR(5)
  ) u_regs (
    .clk(clk_bus), .por_n(por_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .run_sel(run_sel),
    .stop_sel(stop_sel), .width(width)
  );

  // One pin synchroniser per clock domain.
  assign dom_clk[DOM_BUS] = clk_bus;
  assign dom_clk[DOM_LP]  = clk_lp;

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom_sync
    rpf_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(dom_clk[d]), .rst_n(por_n), .din(pin_n), .dout(dom_sync[d])
    );
  end

  assign bus_sync = dom_sync[DOM_BUS];
  assign lp_sync  = dom_sync[DOM_LP];

  assign sel     = pick_filter(run_sel, stop_sel, stop_mode);
  assign bus_clr = (sel != SEL_BUS) || stop_mode;
  assign lp_clr  = (sel != SEL_LP) || lls_mode;

  rpf_stable_filter #(.CNT_W(WIDTH_BITS)) u_bus_flt (
    .clk(clk_bus), .rst_n(por_n), .clr(bus_clr), .din(bus_sync),
    .need_m1(width), .lvl(bus_lvl)
  );

  rpf_stable_filter #(.CNT_W(LP_CW)) u_lp_flt (
    .clk(clk_lp), .rst_n(por_n), .clr(lp_clr), .din(lp_sync),
    .need_m1(LP_CW'(LP_COUNT - 1)), .lvl(lp_lvl)
  );

  always_comb begin
    case (sel)
      SEL_BUS: rst_req = ~bus_lvl;
      SEL_LP:  rst_req = ~lp_lvl;
      default: rst_req = ~bus_sync;
    endcase
  end
endmodule

// File: rtl/rstpin_glitch_filter_chk.sv
module rstpin_glitch_filter_chk (
  input logic       clk_bus,
  input logic       clk_lp,
  input logic       por_n,
  input logic       stop_mode,
  input logic       lls_mode,
  input logic       reg_we,
  input logic [2:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       bus_clr,
  input logic       bus_sync,
  input logic       bus_lvl,
  input logic       lp_lvl
);
  // R4: the bus filter moves only to the level its synchronised input had
  p_bus_flip_r4: assert property (@(posedge clk_bus) disable iff (!por_n)
    (!$stable(bus_lvl) && !$past(bus_clr)) |-> (bus_lvl == $past(bus_sync)));

  // R8: stop mode holds the bus filter cleared
  p_bus_stop_clear_r8: assert property (@(posedge clk_bus) disable iff (!por_n)
    stop_mode |=> bus_lvl);

  // R9: low-leakage stop holds the low-power filter cleared
  p_lp_lls_clear_r9: assert property (@(posedge clk_lp) disable iff (!por_n)
    lls_mode |=> lp_lvl);

  // R2: a width write reads back masked to five bits
  p_width_rd_r2: assert property (@(posedge clk_bus) disable iff (!por_n)
    ($past(reg_we) && $past(reg_addr) == 3'd5 && reg_addr == 3'd5)
      |-> (reg_rdata == {3'b000, $past(reg_wdata[4:0])}));
endmodule

bind rstpin_glitch_filter rstpin_glitch_filter_chk u_chk (
  .clk_bus(clk_bus), .clk_lp(clk_lp), .por_n(por_n),
  .stop_mode(stop_mode), .lls_mode(lls_mode), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .bus_clr(bus_clr), .bus_sync(bus_sync), .bus_lvl(bus_lvl), .lp_lvl(lp_lvl)
);

// File: tb/rstpin_glitch_filter_test.sv
`timescale 1ns/1ps
module rstpin_glitch_filter_test;
  logic       clk_bus = 1'b0, clk_lp = 1'b0;
  logic       por_n = 1'b0, pin_n = 1'b1, stop_mode = 1'b0, lls_mode = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       rst_req;

  int n_chk = 0, n_fail = 0;
  logic seen = 1'b0, mon_en = 1'b0;
  logic [7:0] rd;

  always #2  clk_bus = ~clk_bus;   // 250 MHz
  always #16 clk_lp  = ~clk_lp;    // eight bus periods

  rstpin_glitch_filter uut (
    .clk_bus(clk_bus), .clk_lp(clk_lp), .por_n(por_n), .pin_n(pin_n),
    .stop_mode(stop_mode), .lls_mode(lls_mode), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rst_req(rst_req)
  );

  always @(posedge clk_bus) if (mon_en && rst_req) seen <= 1'b1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_bus); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk_bus); reg_we = 1'b0;
  endtask

  task automatic rdreg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk_bus); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_bus);
  endtask

  // {run_sel[17:16], stop_sel[15], stop[14], width[13:9], len[8:1], expect[0]}
  localparam int NV = 12;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b0, 5'd0,  8'd1,  1'b1},  // R3 bypass passes a glitch
    {2'd1, 1'b0, 1'b0, 5'd0,  8'd1,  1'b1},  // R4 count of one
    {2'd1, 1'b0, 1'b0, 5'd3,  8'd3,  1'b0},  // R4 one short
    {2'd1, 1'b0, 1'b0, 5'd3,  8'd4,  1'b1},  // R4 exact
    {2'd1, 1'b0, 1'b0, 5'd31, 8'd31, 1'b0},  // R4 max minus one
    {2'd1, 1'b0, 1'b0, 5'd31, 8'd32, 1'b1},  // R4 max
    {2'd2, 1'b0, 1'b0, 5'd0,  8'd16, 1'b0},  // R5 two lp clocks
    {2'd2, 1'b0, 1'b0, 5'd0,  8'd40, 1'b1},  // R5 five lp clocks
    {2'd3, 1'b0, 1'b0, 5'd31, 8'd1,  1'b1},  // R6 reserved selects nothing
    {2'd1, 1'b0, 1'b1, 5'd31, 8'd1,  1'b1},  // R7 stop bypass ignores run_sel
    {2'd1, 1'b1, 1'b1, 5'd31, 8'd16, 1'b0},  // R7 stop lp rejects
    {2'd1, 1'b1, 1'b1, 5'd31, 8'd40, 1'b1}   // R7 stop lp accepts
  };

  initial begin
    #600000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(4); por_n = 1'b1; cyc(4);
    // R1 reset state
    check(rst_req == 1'b0, "R1 idle output", rst_req, 0);
    rdreg(3'd4, rd); check(rd == 8'h00, "R1 ctrl reset", rd, 0);
    rdreg(3'd5, rd); check(rd == 8'h00, "R1 width reset", rd, 0);

    // R2 field masking and unused addresses
    wr(3'd4, 8'hFF); rdreg(3'd4, rd); check(rd == 8'h07, "R2 ctrl mask", rd, 7);
    wr(3'd5, 8'hFF); rdreg(3'd5, rd); check(rd == 8'h1F, "R2 width mask", rd, 31);
    rdreg(3'd0, rd); check(rd == 8'h00, "R2 unused addr 0", rd, 0);
    rdreg(3'd6, rd); check(rd == 8'h00, "R2 unused addr 6", rd, 0);

    for (int i = 0; i < NV; i++) begin
      wr(3'd4, {5'd0, VEC[i][15], VEC[i][17:16]});
      wr(3'd5, {3'd0, VEC[i][13:9]});
      stop_mode = VEC[i][14];
      cyc(40);
      seen = 1'b0; mon_en = 1'b1;
      @(negedge clk_bus); pin_n = 1'b0;
      cyc(int'(VEC[i][8:1]));
      pin_n = 1'b1;
      cyc(120);
      mon_en = 1'b0;
      check(seen == VEC[i][0], $sformatf("R3-7 vector %0d pulse", i), seen, VEC[i][0]);
      check(rst_req == 1'b0, $sformatf("R4 vector %0d release", i), rst_req, 0);
      stop_mode = 1'b0;
    end

    // R4 exact latency, width 4 -> edge 7 after pin change
    wr(3'd4, 8'h01); wr(3'd5, 8'h04); cyc(10);
    pin_n = 1'b0;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk_bus);
      check(rst_req == (k == 7), $sformatf("R4 latency k=%0d", k), rst_req, (k == 7));
    end
    pin_n = 1'b1; cyc(50);

    // R3 bypass latency of two
    wr(3'd4, 8'h00); cyc(10);
    pin_n = 1'b0;
    @(negedge clk_bus); check(rst_req == 1'b0, "R3 latency 1", rst_req, 0);
    @(negedge clk_bus); check(rst_req == 1'b1, "R3 latency 2", rst_req, 1);
    pin_n = 1'b1; cyc(10);

    // R8 deselect mid-count restarts the bus filter
    wr(3'd4, 8'h01); wr(3'd5, 8'h1F); cyc(10);
    pin_n = 1'b0; cyc(20);
    wr(3'd4, 8'h02); wr(3'd4, 8'h01);
    cyc(25); check(rst_req == 1'b0, "R8 deselect restart early", rst_req, 0);
    cyc(15); check(rst_req == 1'b1, "R8 deselect restart late", rst_req, 1);
    pin_n = 1'b1; cyc(50);

    // R8 stop mid-count restarts the bus filter
    pin_n = 1'b0; cyc(20);
    stop_mode = 1'b1; cyc(2); stop_mode = 1'b0;
    cyc(25); check(rst_req == 1'b0, "R8 stop restart early", rst_req, 0);
    cyc(15); check(rst_req == 1'b1, "R8 stop restart late", rst_req, 1);
    pin_n = 1'b1; cyc(50);

    // R9 low-leakage stop holds the lp filter clear
    wr(3'd4, 8'h02); lls_mode = 1'b1; cyc(10);
    seen = 1'b0; mon_en = 1'b1;
    pin_n = 1'b0; cyc(80);
    mon_en = 1'b0;
    check(seen == 1'b0, "R9 held clear", seen, 0);
    lls_mode = 1'b0; cyc(60);
    check(rst_req == 1'b1, "R9 after release", rst_req, 1);
    pin_n = 1'b1; cyc(80);
    check(rst_req == 1'b0, "R9 deassert", rst_req, 0);

    // R10 retention through activity, cleared only by power-on reset
    wr(3'd4, 8'h06); wr(3'd5, 8'h0A);
    stop_mode = 1'b1; lls_mode = 1'b1; pin_n = 1'b0; cyc(30);
    stop_mode = 1'b0; lls_mode = 1'b0; pin_n = 1'b1; cyc(80);
    rdreg(3'd4, rd); check(rd == 8'h06, "R10 ctrl kept", rd, 6);
    rdreg(3'd5, rd); check(rd == 8'h0A, "R10 width kept", rd, 10);
    @(negedge clk_bus); por_n = 1'b0; cyc(2); por_n = 1'b1; cyc(4);
    rdreg(3'd4, rd); check(rd == 8'h00, "R10 ctrl after por", rd, 0);
    rdreg(3'd5, rd); check(rd == 8'h00, "R10 width after por", rd, 0);
    check(rst_req == 1'b0, "R1 idle after por", rst_req, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule